// File: doc/BRIEF.md
# Multichannel Serial Port Channel Gating Controller

This block sits beside the bit engine of a time-slot-multiplexed serial port and decides, slot by slot, whether any data moves. For each direction it looks up which channel owns the current slot, checks the group-wide enable for that direction and checks whether that channel is currently live. From these it produces a registered transmit data request, output-enable and forced-ones control, and a registered receive accept strobe, each with the owning channel number.

Each channel has one liveness bit per direction. An activation or jump request sets it. Any of four stop events clears it: suspend, idle, abort or controller shutdown. Once cleared, the bit stays clear until a fresh request arrives. Every stop event whose kind is not masked is recorded in a small event queue. The record holds the kind, the direction, the channel and the group number. When the queue is full, further records are discarded and a sticky overflow flag is raised.

All per-slot decisions are sampled on a slot strobe and held until the next strobe. The output enable and the forced-ones bit therefore always change together at a slot boundary.

Top module: `cg_chan_gate`

## Requirements
- R1: On a slot strobe, `tx_data_req` is registered as 1 only when `grp_tx_en` is 1, bit `slot_idx` of `tx_map_vld` is 1, and the transmit liveness bit of the channel in field `tx_map_ch[slot_idx*CH_W +: CH_W]` is 1. When the request is 1, `tx_req_ch` gives that channel.
- R2: A slot strobe with `grp_tx_en` at 0 registers `tx_oe`=0, `tx_force_one`=0 and `tx_data_req`=0, whatever the map and liveness state.
- R3: A slot strobe with `grp_tx_en` at 1 on an unmapped slot or an inactive channel registers `tx_data_req`=0. It then registers `tx_oe`=0 and `tx_force_one`=0 when `grp_dead_hiz` is 1, and `tx_oe`=1 and `tx_force_one`=1 when `grp_dead_hiz` is 0. A live slot registers `tx_oe`=1 and `tx_force_one`=0.
- R4: On a slot strobe, `rx_accept` is registered as 1 only when `grp_rx_en` is 1, bit `slot_idx` of `rx_map_vld` is 1, and the receive liveness bit of the channel in `rx_map_ch[slot_idx*CH_W +: CH_W]` is 1. When it is 1, `rx_acc_ch` gives that channel. In every other case the incoming bit is discarded (`rx_accept`=0).
- R5: Several receive slots may name the same channel. Each such slot is accepted while that channel is live.
- R6: A stop event (`stop_vld`=1; `stop_kind` 0 suspend, 1 idle, 2 abort, 3 shutdown; `stop_dir` 0 transmit, 1 receive) clears the liveness bit of `stop_ch` in that direction from the next cycle onward. The bit stays clear until that channel's activation or jump request in that direction is raised.
- R7: If an activation request and a stop event reach the same channel and direction in the same cycle, the channel ends up inactive.
- R8: Transmit and receive liveness are independent. A stop or request in one direction leaves the other direction of the same channel unchanged.
- R9: A stop event whose `evt_mask[stop_kind]` bit is 0 pushes a record {kind, direction, channel, `grp_id`}. The record appears on `evt_kind`, `evt_dir`, `evt_ch` and `evt_grp` with `evt_vld`=1 from the next cycle. If the mask bit is 1, no record is pushed, but the channel is still deactivated.
- R10: Records leave the queue in arrival order, one per cycle in which `evt_pop` is 1. A record arriving while `EVT_DEPTH` records are held is dropped and sets `evt_ovf`. The flag stays set until `evt_ovf_clr` is 1.
- R11: The slot outputs change only on the clock edge that samples `slot_stb`=1. Between strobes they hold their value even when the enables or the liveness state change.
- R12: After reset, all liveness bits are 0, all slot outputs are 0, the queue is empty and `evt_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_id | input | GRP_W | Group number placed in event records |
| grp_tx_en | input | 1 | Group transmit enable |
| grp_rx_en | input | 1 | Group receive enable |
| grp_dead_hiz | input | 1 | 1: dead transmit slots float; 0: dead transmit slots drive ones |
| tx_map_vld | input | NUM_SLOTS | Per-slot transmit mapping valid |
| tx_map_ch | input | NUM_SLOTS*CH_W | Per-slot transmit channel, slot s at bits s*CH_W |
| rx_map_vld | input | NUM_SLOTS | Per-slot receive mapping valid |
| rx_map_ch | input | NUM_SLOTS*CH_W | Per-slot receive channel, slot s at bits s*CH_W |
| slot_stb | input | 1 | Slot boundary strobe |
| slot_idx | input | SLOT_W | Index of the slot being decided |
| tx_act_req | input | NUM_CH | Transmit activation requests |
| tx_jmp_req | input | NUM_CH | Transmit jump requests |
| rx_act_req | input | NUM_CH | Receive activation requests |
| rx_jmp_req | input | NUM_CH | Receive jump requests |
| stop_vld | input | 1 | Stop event valid |
| stop_dir | input | 1 | Stop direction (0 tx, 1 rx) |
| stop_ch | input | CH_W | Stopped channel |
| stop_kind | input | 2 | Stop kind code |
| evt_mask | input | 4 | Per-kind record suppression |
| evt_pop | input | 1 | Remove head record |
| evt_ovf_clr | input | 1 | Clear overflow flag |
| tx_data_req | output | 1 | Transmit data request for the slot |
| tx_req_ch | output | CH_W | Transmit channel of the slot |
| tx_oe | output | 1 | Serial output enable |
| tx_force_one | output | 1 | Drive constant 1 instead of data |
| rx_accept | output | 1 | Receive bit accepted for the slot |
| rx_acc_ch | output | CH_W | Receive channel of the slot |
| evt_vld | output | 1 | Head record valid |
| evt_kind | output | 2 | Head record stop kind |
| evt_dir | output | 1 | Head record direction |
| evt_ch | output | CH_W | Head record channel |
| evt_grp | output | GRP_W | Head record group |
| evt_ovf | output | 1 | Sticky record-drop flag |

## Verification
The bench builds the block with NUM_CH=4, NUM_SLOTS=8, GRP_W=2 and EVT_DEPTH=4. At these values all 16 liveness patterns of each direction can be swept against every slot and all four enable and float-select combinations. The fixed maps contain unmapped slots and two receive slots that share a channel. With a four-deep queue, five events are enough to show in-order drain, drop on full and the sticky overflow flag. Directed cases cover the stop-versus-request collision, wake-up by jump, direction independence, masked kinds and output holding between strobes.

// File: rtl/cg_pkg.sv
// Package: shared codes for the channel gating controller.
// Assumes: stop kinds fit two bits; direction is a single bit.
package cg_pkg;
    typedef enum logic [1:0] {
        STOP_SUSPEND  = 2'd0,
        STOP_IDLE     = 2'd1,
        STOP_ABORT    = 2'd2,
        STOP_SHUTDOWN = 2'd3
    } stop_kind_e;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int NUM_DIR = 2;
    localparam int KIND_W = 2;
endpackage

// File: rtl/cg_chan_state.sv
// Module: per-channel liveness bits for one direction.
// A request (activation or jump) sets a bit; a stop clears it; stop wins.
// Assumes: request and stop vectors are one cycle wide pulses or levels.
module cg_chan_state #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] act_req,
    input  logic [NUM_CH-1:0] jmp_req,
    input  logic [NUM_CH-1:0] stop_vec,
    output logic [NUM_CH-1:0] active
);
    logic [NUM_CH-1:0] wake;

    // Any service request kind wakes a channel.
    always_comb wake = act_req | jmp_req;

    // Liveness update: stop has priority over wake in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= (active | wake) & ~stop_vec;
    end

    // R6/R7: a stopped channel is inactive the cycle after.
    a_r7_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_vec != '0) |=> ((active & $past(stop_vec)) == '0));

    // R6: no channel comes alive without a request.
    a_r6_no_self_wake: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((active & ~$past(active) & ~$past(wake)) == '0));
endmodule

// File: rtl/cg_slot_lookup.sv
// Module: combinational slot-to-channel lookup for one direction.
// Gives the channel owning the slot and whether that slot is live
// (mapped and its channel active). Assumes slot_idx < NUM_SLOTS.
module cg_slot_lookup #(
    parameter int NUM_CH    = 8,
    parameter int NUM_SLOTS = 32,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [SLOT_W-1:0]         slot_idx,
    input  logic [NUM_SLOTS-1:0]      map_vld,
    input  logic [NUM_SLOTS*CH_W-1:0] map_ch,
    input  logic [NUM_CH-1:0]         active,
    output logic                      live,
    output logic [CH_W-1:0]           ch
);
    // Select the slot's channel field and qualify by map and liveness.
    always_comb begin
        ch   = map_ch[int'(slot_idx)*CH_W +: CH_W];
        live = map_vld[slot_idx] & active[ch];
    end
endmodule

// File: rtl/cg_evt_fifo.sv
// Module: small event record queue with sticky overflow.
// A push while full is dropped and sets ovf; ovf clears only on ovf_clr
// (a drop in the same cycle keeps it set). Assumes DEPTH >= 2.
module cg_evt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         ovf_clr,
    output logic         head_vld,
    output logic [W-1:0] head_data,
    output logic         ovf
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept/remove qualification against occupancy.
    always_comb begin
        full     = (cnt == CNT_W'(DEPTH));
        do_push  = push && !full;
        do_pop   = pop && (cnt != '0);
        head_vld = (cnt != '0);
        head_data = mem[rd_ptr];
    end

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer, count and overflow flag maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (push && full) ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    a_r10_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf);
    a_r10_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(push && full)) |=> !ovf);
    a_r10_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/cg_chan_gate.sv
// Module: top of the channel gating controller.
// Per direction: liveness bits and a slot lookup (generated). On each
// slot strobe the tx/rx decisions are registered together. Stop events
// are decoded into per-direction clear vectors and, unless masked,
// queued as records. Assumes one stop event per cycle at most.
module cg_chan_gate
    import cg_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int NUM_SLOTS = 32,
    parameter int GRP_W     = 2,
    parameter int EVT_DEPTH = 4,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [GRP_W-1:0]          grp_id,
    input  logic                      grp_tx_en,
    input  logic                      grp_rx_en,
    input  logic                      grp_dead_hiz,
    input  logic [NUM_SLOTS-1:0]      tx_map_vld,
    input  logic [NUM_SLOTS*CH_W-1:0] tx_map_ch,
    input  logic [NUM_SLOTS-1:0]      rx_map_vld,
    input  logic [NUM_SLOTS*CH_W-1:0] rx_map_ch,
    input  logic                      slot_stb,
    input  logic [SLOT_W-1:0]         slot_idx,
    input  logic [NUM_CH-1:0]         tx_act_req,
    input  logic [NUM_CH-1:0]         tx_jmp_req,
    input  logic [NUM_CH-1:0]         rx_act_req,
    input  logic [NUM_CH-1:0]         rx_jmp_req,
    input  logic                      stop_vld,
    input  logic                      stop_dir,
    input  logic [CH_W-1:0]           stop_ch,
    input  logic [1:0]                stop_kind,
    input  logic [3:0]                evt_mask,
    input  logic                      evt_pop,
    input  logic                      evt_ovf_clr,
    output logic                      tx_data_req,
    output logic [CH_W-1:0]           tx_req_ch,
    output logic                      tx_oe,
    output logic                      tx_force_one,
    output logic                      rx_accept,
    output logic [CH_W-1:0]           rx_acc_ch,
    output logic                      evt_vld,
    output logic [1:0]                evt_kind,
    output logic                      evt_dir,
    output logic [CH_W-1:0]           evt_ch,
    output logic [GRP_W-1:0]          evt_grp,
    output logic                      evt_ovf
);
    localparam int REC_W = KIND_W + 1 + CH_W + GRP_W;

    logic [NUM_DIR-1:0][NUM_CH-1:0]         act_all, jmp_all, stop_all, active_all;
    logic [NUM_DIR-1:0][NUM_SLOTS-1:0]      vld_all;
    logic [NUM_DIR-1:0][NUM_SLOTS*CH_W-1:0] chmap_all;
    logic [NUM_DIR-1:0]                     live_all;
    logic [NUM_DIR-1:0][CH_W-1:0]           ch_all;
    logic                                   rec_push;
    logic [REC_W-1:0]                       rec_in, rec_head;

    // Gather per-direction inputs into direction-indexed arrays.
    always_comb begin
        act_all[DIR_TX]   = tx_act_req;
        act_all[DIR_RX]   = rx_act_req;
        jmp_all[DIR_TX]   = tx_jmp_req;
        jmp_all[DIR_RX]   = rx_jmp_req;
        vld_all[DIR_TX]   = tx_map_vld;
        vld_all[DIR_RX]   = rx_map_vld;
        chmap_all[DIR_TX] = tx_map_ch;
        chmap_all[DIR_RX] = rx_map_ch;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        // Decode the stop event into a one-hot clear for this direction.
        always_comb begin
            stop_all[d] = (stop_vld && (stop_dir == 1'(d)))
                        ? (NUM_CH'(1) << stop_ch) : '0;
        end

        cg_chan_state #(.NUM_CH(NUM_CH)) u_state (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_req  (act_all[d]),
            .jmp_req  (jmp_all[d]),
            .stop_vec (stop_all[d]),
            .active   (active_all[d])
        );

        cg_slot_lookup #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) u_lookup (
            .slot_idx (slot_idx),
            .map_vld  (vld_all[d]),
            .map_ch   (chmap_all[d]),
            .active   (active_all[d]),
            .live     (live_all[d]),
            .ch       (ch_all[d])
        );
    end

    // Register all per-slot decisions together at the slot strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data_req  <= 1'b0;
            tx_req_ch    <= '0;
            tx_oe        <= 1'b0;
            tx_force_one <= 1'b0;
            rx_accept    <= 1'b0;
            rx_acc_ch    <= '0;
        end else if (slot_stb) begin
            tx_data_req  <= grp_tx_en && live_all[DIR_TX];
            tx_req_ch    <= ch_all[DIR_TX];
            tx_oe        <= grp_tx_en && (live_all[DIR_TX] || !grp_dead_hiz);
            tx_force_one <= grp_tx_en && !live_all[DIR_TX] && !grp_dead_hiz;
            rx_accept    <= grp_rx_en && live_all[DIR_RX];
            rx_acc_ch    <= ch_all[DIR_RX];
        end
    end

    // Build the event record for unmasked stop kinds.
    always_comb begin
        rec_push = stop_vld && !evt_mask[stop_kind];
        rec_in   = {stop_kind, stop_dir, stop_ch, grp_id};
    end

    cg_evt_fifo #(.W(REC_W), .DEPTH(EVT_DEPTH)) u_evtq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rec_push),
        .push_data (rec_in),
        .pop       (evt_pop),
        .ovf_clr   (evt_ovf_clr),
        .head_vld  (evt_vld),
        .head_data (rec_head),
        .ovf       (evt_ovf)
    );

    // Split the head record into its fields.
    always_comb begin
        evt_kind = rec_head[REC_W-1 -: KIND_W];
        evt_dir  = rec_head[CH_W + GRP_W];
        evt_ch   = rec_head[GRP_W +: CH_W];
        evt_grp  = rec_head[GRP_W-1:0];
    end

    a_r2_float_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && !grp_tx_en) |=> (!tx_oe && !tx_data_req));
    a_r3_ones_only_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
        tx_force_one |-> (tx_oe && !tx_data_req));
    a_r4_rx_off_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && !grp_rx_en) |=> !rx_accept);
    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> ($stable(tx_data_req) && $stable(tx_oe) &&
                       $stable(tx_force_one) && $stable(rx_accept)));
endmodule

// File: tb/cg_chan_gate_tb.sv
`timescale 1ns/1ps
module cg_chan_gate_tb_top;
    localparam int NC = 4;
    localparam int NS = 8;
    localparam int CW = 2;
    localparam int SW = 3;
    localparam int GW = 2;
    localparam int DEP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [GW-1:0] grp_id = '0;
    logic grp_tx_en = 0, grp_rx_en = 0, grp_dead_hiz = 0;
    logic [NS-1:0] tx_map_vld, rx_map_vld;
    logic [NS*CW-1:0] tx_map_ch, rx_map_ch;
    logic slot_stb = 0;
    logic [SW-1:0] slot_idx = '0;
    logic [NC-1:0] tx_act_req = '0, tx_jmp_req = '0, rx_act_req = '0, rx_jmp_req = '0;
    logic stop_vld = 0, stop_dir = 0;
    logic [CW-1:0] stop_ch = '0;
    logic [1:0] stop_kind = '0;
    logic [3:0] evt_mask = '0;
    logic evt_pop = 0, evt_ovf_clr = 0;
    logic tx_data_req, tx_oe, tx_force_one, rx_accept, evt_vld, evt_dir, evt_ovf;
    logic [CW-1:0] tx_req_ch, rx_acc_ch, evt_ch;
    logic [1:0] evt_kind;
    logic [GW-1:0] evt_grp;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cg_chan_gate #(.NUM_CH(NC), .NUM_SLOTS(NS), .GRP_W(GW), .EVT_DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .grp_id(grp_id), .grp_tx_en(grp_tx_en),
        .grp_rx_en(grp_rx_en), .grp_dead_hiz(grp_dead_hiz),
        .tx_map_vld(tx_map_vld), .tx_map_ch(tx_map_ch),
        .rx_map_vld(rx_map_vld), .rx_map_ch(rx_map_ch),
        .slot_stb(slot_stb), .slot_idx(slot_idx),
        .tx_act_req(tx_act_req), .tx_jmp_req(tx_jmp_req),
        .rx_act_req(rx_act_req), .rx_jmp_req(rx_jmp_req),
        .stop_vld(stop_vld), .stop_dir(stop_dir), .stop_ch(stop_ch),
        .stop_kind(stop_kind), .evt_mask(evt_mask), .evt_pop(evt_pop),
        .evt_ovf_clr(evt_ovf_clr), .tx_data_req(tx_data_req), .tx_req_ch(tx_req_ch),
        .tx_oe(tx_oe), .tx_force_one(tx_force_one), .rx_accept(rx_accept),
        .rx_acc_ch(rx_acc_ch), .evt_vld(evt_vld), .evt_kind(evt_kind),
        .evt_dir(evt_dir), .evt_ch(evt_ch), .evt_grp(evt_grp), .evt_ovf(evt_ovf)
    );

    // Fixed maps: tx slots 3 and 6 unmapped, tx channel = s%4;
    // rx slot 1 unmapped, rx channel = (3*s)%4 (slots 0 and 4 share ch0).
    function automatic bit tx_mapped(int s); return (s != 3) && (s != 6); endfunction
    function automatic int tx_chan(int s); return s % 4; endfunction
    function automatic bit rx_mapped(int s); return s != 1; endfunction
    function automatic int rx_chan(int s); return (3 * s) % 4; endfunction

    initial begin
        for (int s = 0; s < NS; s++) begin
            tx_map_vld[s] = tx_mapped(s);
            rx_map_vld[s] = rx_mapped(s);
            tx_map_ch[s*CW +: CW] = CW'(tx_chan(s));
            rx_map_ch[s*CW +: CW] = CW'(rx_chan(s));
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic probe(input int s);
        slot_stb = 1'b1;
        slot_idx = SW'(s);
        step();
        slot_stb = 1'b0;
    endtask

    task automatic stop_ev(input int dir, input int ch, input int kind);
        stop_vld = 1'b1; stop_dir = 1'(dir); stop_ch = CW'(ch); stop_kind = 2'(kind);
        step();
        stop_vld = 1'b0;
    endtask

    // Force one direction's liveness to exactly 'mask' without records.
    task automatic set_active(input int dir, input logic [NC-1:0] mask);
        logic [3:0] saved;
        saved = evt_mask;
        evt_mask = 4'hF;
        for (int c = 0; c < NC; c++) stop_ev(dir, c, c);
        if (dir == 0) tx_act_req = mask; else rx_act_req = mask;
        step();
        tx_act_req = '0; rx_act_req = '0;
        evt_mask = saved;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 tx_data_req", int'(tx_data_req), 0);
        chk("R12 tx_oe", int'(tx_oe), 0);
        chk("R12 rx_accept", int'(rx_accept), 0);
        chk("R12 evt_vld", int'(evt_vld), 0);
        chk("R12 evt_ovf", int'(evt_ovf), 0);
        grp_tx_en = 1; grp_rx_en = 1; grp_dead_hiz = 1;
        probe(0);
        chk("R12 tx inactive after reset", int'(tx_data_req), 0);
        chk("R12 rx inactive after reset", int'(rx_accept), 0);

        // R1 R2 R3 R4 R5: sweep liveness patterns, enables, select, slots
        for (int m = 0; m < 16; m++) begin
            logic [NC-1:0] txm, rxm;
            txm = NC'(m);
            rxm = NC'(m) ^ 4'b0101;
            set_active(0, txm);
            set_active(1, rxm);
            for (int cfg = 0; cfg < 4; cfg++) begin
                grp_tx_en = cfg[0]; grp_rx_en = cfg[0]; grp_dead_hiz = cfg[1];
                for (int s = 0; s < NS; s++) begin
                    bit tl, rl, en, hz;
                    en = cfg[0]; hz = cfg[1];
                    tl = tx_mapped(s) && txm[tx_chan(s)];
                    rl = rx_mapped(s) && rxm[rx_chan(s)];
                    probe(s);
                    chk("R1 tx_data_req", int'(tx_data_req), int'(en && tl));
                    if (en && tl) chk("R1 tx_req_ch", int'(tx_req_ch), tx_chan(s));
                    if (!en) chk("R2 tx_oe off", int'(tx_oe), 0);
                    else chk("R3 tx_oe", int'(tx_oe), int'(tl || !hz));
                    chk("R3 tx_force_one", int'(tx_force_one), int'(en && !tl && !hz));
                    chk("R4 rx_accept", int'(rx_accept), int'(en && rl));
                    if (en && rl) chk("R4 R5 rx_acc_ch", int'(rx_acc_ch), rx_chan(s));
                end
            end
        end

        grp_tx_en = 1; grp_rx_en = 1; grp_dead_hiz = 1;
        // R5: slots 0 and 4 both accepted for rx ch0
        set_active(1, 4'b0001);
        probe(0); chk("R5 slot0 ch0", int'(rx_accept), 1);
        probe(4); chk("R5 slot4 ch0", int'(rx_accept), 1);

        // R7: request and stop on tx ch1 in same cycle -> inactive
        set_active(0, 4'b0000);
        evt_mask = 4'hF;
        tx_act_req = 4'b0010;
        stop_ev(0, 1, 0);
        tx_act_req = '0;
        probe(1); chk("R7 stop beats request", int'(tx_data_req), 0);
        tx_act_req = 4'b0010; step(); tx_act_req = '0;
        probe(1); chk("R7 reissued request", int'(tx_data_req), 1);

        // R6: abort on tx ch2, stays dead, jump revives
        set_active(0, 4'b0100);
        stop_ev(0, 2, 2);
        probe(2); chk("R6 dead after abort", int'(tx_data_req), 0);
        repeat (3) step();
        probe(2); chk("R6 still dead", int'(tx_data_req), 0);
        tx_jmp_req = 4'b0100; step(); tx_jmp_req = '0;
        probe(2); chk("R6 jump revives", int'(tx_data_req), 1);

        // R8: tx stop on ch0 leaves rx ch0 live
        set_active(0, 4'hF);
        set_active(1, 4'hF);
        stop_ev(0, 0, 3);
        probe(0);
        chk("R8 tx ch0 stopped", int'(tx_data_req), 0);
        chk("R8 rx ch0 untouched", int'(rx_accept), 1);

        // R9: record fields and masking
        evt_mask = 4'h0; grp_id = 2'd2;
        stop_ev(1, 3, 1);
        chk("R9 evt_vld", int'(evt_vld), 1);
        chk("R9 evt_kind", int'(evt_kind), 1);
        chk("R9 evt_dir", int'(evt_dir), 1);
        chk("R9 evt_ch", int'(evt_ch), 3);
        chk("R9 evt_grp", int'(evt_grp), 2);
        evt_pop = 1; step(); evt_pop = 0;
        chk("R9 popped empty", int'(evt_vld), 0);
        set_active(1, 4'hF);
        evt_mask = 4'b0100;
        stop_ev(1, 1, 2);
        chk("R9 masked no record", int'(evt_vld), 0);
        probe(3); chk("R9 masked still deactivates", int'(rx_accept), 0);

        // R10: fill beyond depth, drop, order, sticky flag, clear
        evt_mask = 4'h0; grp_id = 2'd1;
        for (int i = 0; i < 5; i++) stop_ev(i % 2, i % 4, (i + 1) % 4);
        chk("R10 ovf after drop", int'(evt_ovf), 1);
        for (int i = 0; i < 4; i++) begin
            chk("R10 order vld", int'(evt_vld), 1);
            chk("R10 order kind", int'(evt_kind), (i + 1) % 4);
            chk("R10 order dir", int'(evt_dir), i % 2);
            chk("R10 order ch", int'(evt_ch), i % 4);
            evt_pop = 1; step(); evt_pop = 0;
        end
        chk("R10 fifth dropped", int'(evt_vld), 0);
        chk("R10 ovf sticky", int'(evt_ovf), 1);
        evt_ovf_clr = 1; step(); evt_ovf_clr = 0;
        chk("R10 ovf cleared", int'(evt_ovf), 0);

        // R11: outputs hold between strobes
        set_active(0, 4'hF);
        grp_tx_en = 1;
        probe(0);
        chk("R11 baseline req", int'(tx_data_req), 1);
        grp_tx_en = 0;
        tx_act_req = '0;
        repeat (3) step();
        chk("R11 held req", int'(tx_data_req), 1);
        chk("R11 held oe", int'(tx_oe), 1);
        probe(0);
        chk("R11 updates on strobe", int'(tx_oe), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule